// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block sits on the send side of a packet MAC. Software prepares frames in system memory and describes each one with a pair of words in a small descriptor RAM. The first word holds the status and length, and the second holds the buffer pointer. The engine polls the descriptor at its current ring position. When that descriptor is marked ready, the engine copies the frame out of memory one 32-bit word at a time into a local frame buffer. It then plays the frame out as a byte stream.

The byte sink answers each frame with a done or fail pulse. The engine then writes an updated status word back to the same descriptor and sets a sticky interrupt-source bit. It raises the interrupt line when either mask bit allows it, and steps to the next descriptor pair. A per-frame CRC-append decision and a latched late-CRC mode are presented to the downstream framer. The engine does not compute the CRC itself.

Top module: `txdesc_dma_engine`

## Requirements
- R1: While reset is low and on the first cycle after it, `dr_addr` is 0, and `mem_req`, `tx_valid`, `dr_we` and `irq` are 0, and `int_src` is 2'b00.
- R2: The engine polls descriptors only while `cfg_tx_en` is 1. If the enable is cleared while the engine is polling, it returns to idle. While the enable is low, no memory read and no stream byte occur even if a ready descriptor is present.
- R3: A descriptor at even index i has its status word at address i and its buffer pointer at address i+1. The status word holds the frame length in bits 31:16, ready in bit 15, wrap in bit 14, CRC request in bit 13, last-fragment in bit 12 and the collision flag in bit 3. A descriptor whose ready bit is 0 is polled again and never fetched.
- R4: The frame is read as ceil(length/4) word reads at pointer+0, pointer+4 and so on, in order. `mem_addr` and `mem_req` hold steady until `mem_ack`.
- R5: Stream byte n equals byte (n mod 4) of word n/4, where byte 0 is bits 31:24 and byte 3 is bits 7:0. Exactly `length` bytes are sent, even when the final word carries more. `tx_last` marks the final byte, and no byte follows it.
- R6: No stream byte is offered while any word of the frame is still being read.
- R7: `crc_add` is `cfg_crc_all` OR (descriptor CRC bit AND last bit). Both it and `crc_late` are taken from the mode inputs when the descriptor is accepted, and they hold for the whole frame.
- R8: On a done response, the descriptor's status word is written back with only the ready bit cleared, and `int_src[0]` is set.
- R9: On a fail response, the status word is written back with the ready and collision bits cleared, and `int_src[1]` is set. When fail and done arrive together, fail is taken.
- R10: After a frame, the index becomes 0 if the wrap bit was set or the index was RING_WORDS-2. Otherwise it advances by 2.
- R11: `irq` pulses for exactly one cycle, on the cycle after the response, when `irq_mask_ok` or `irq_mask_err` is 1, whatever the outcome of the frame.
- R12: The `int_src` bits stay set until a 1 is written to the matching `src_clr` bit. A 1 on the other clear bit leaves a set bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable mode bit |
| cfg_crc_all | input | 1 | Append CRC to every frame |
| cfg_crc_late | input | 1 | Late-CRC mode, latched per frame |
| irq_mask_ok | input | 1 | Interrupt mask for good sends |
| irq_mask_err | input | 1 | Interrupt mask for failed sends |
| src_clr | input | 2 | Write-one-to-clear for `int_src` |
| dr_addr | output | log2(RING_WORDS) | Descriptor RAM word address |
| dr_rdata | input | 32 | Descriptor RAM read data (asynchronous read) |
| dr_we | output | 1 | Descriptor RAM write strobe |
| dr_wdata | output | 32 | Descriptor status write-back word |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Memory read word |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Sink accepts byte |
| tx_done | input | 1 | Sink reports a good send (pulse) |
| tx_fail | input | 1 | Sink reports a failed send (pulse) |
| crc_add | output | 1 | Framer should append CRC |
| crc_late | output | 1 | Latched late-CRC mode |
| int_src | output | 2 | Sticky sources: [0] sent, [1] error |
| irq | output | 1 | Interrupt pulse |

## Verification
The checks assume the sink responds only after it has taken the byte flagged `tx_last`. They also assume every accepted descriptor has a length from 1 to MAX_FRAME, and that the memory returns data in the same cycle it raises `mem_ack`. The bench keeps within these limits: it answers only after observing the final transfer, it uses lengths of 1 to 64 bytes, and its memory model acks combinationally. In stall mode the model withholds the ack on alternate cycles, and the sink withdraws `tx_ready` on alternate cycles to apply backpressure. Descriptor writes from the bench go through the same RAM port model that the engine writes back into, so write-back and polling see one consistent RAM.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
// Shared types and status-word field positions for the transmit descriptor engine.
package txd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FETCH = 2'd2,
        ST_SEND  = 2'd3
    } txd_state_e;

    localparam int unsigned LEN_LSB = 16;
    localparam int unsigned LEN_W   = 16;
    localparam int unsigned B_READY = 15;
    localparam int unsigned B_WRAP  = 14;
    localparam int unsigned B_CRC   = 13;
    localparam int unsigned B_LAST  = 12;
    localparam int unsigned B_COLL  = 3;
endpackage

// File: rtl/txd_fbuf.sv
`timescale 1ns/1ps
// Frame buffer: takes one 32-bit word per write as four bytes (bits 31:24 at
// the lowest position) and gives one byte per read. Assumes DEPTH is a power
// of two and a multiple of 4, and that write positions are word aligned.
// Storage carries no reset; control logic never reads bytes before writing them.
module txd_fbuf #(
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_pos,
    input  logic [31:0]   wr_word,
    input  logic [PW-1:0] rd_pos,
    output logic [7:0]    rd_byte
);
    logic [7:0] mem [DEPTH];

    // Scatter the four bytes of an incoming word, most significant first.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                mem[wr_pos + PW'(k)] <= wr_word[8*(3-k) +: 8];
            end
        end
    end

    // Byte read port for the stream side.
    assign rd_byte = mem[rd_pos];
endmodule

// File: rtl/txd_fetch.sv
`timescale 1ns/1ps
// Word fetcher: while go is high, reads the frame at base, base+4 and so on
// until the byte count reaches len, and writes each word into the frame buffer.
// Assumes the memory presents rdata in the same cycle as ack. Dropping go
// rewinds the count.
module txd_fetch #(
    parameter int AW    = 32,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = txd_pkg::LEN_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  logic [AW-1:0]              base,
    input  logic [txd_pkg::LEN_W-1:0]  len,
    output logic                       mem_req,
    output logic [AW-1:0]              mem_addr,
    input  logic                       mem_ack,
    input  logic [31:0]                mem_rdata,
    output logic                       wr_en,
    output logic [PW-1:0]              wr_pos,
    output logic [31:0]                wr_word,
    output logic                       done
);
    logic [CW-1:0] sent;
    logic          more;

    assign more     = sent < {1'b0, len};
    assign mem_req  = go && more;
    assign mem_addr = base + AW'(sent);
    assign wr_en    = mem_req && mem_ack;
    assign wr_pos   = sent[PW-1:0];
    assign wr_word  = mem_rdata;
    assign done     = go && !more;

    // Byte count of words already taken from memory.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) sent <= '0;
        else if (wr_en)    sent <= sent + CW'(4);
    end

    // R4: an unanswered request keeps its address and stays up
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/txd_ctrl.sv
`timescale 1ns/1ps
// Sequencer: polls the descriptor ring, starts the fetch, streams the
// buffered frame, writes status back and raises interrupt sources.
// Assumes asynchronous-read descriptor RAM, accepted lengths of 1..MAX_FRAME,
// and a sink that responds only after it has taken the last byte.
module txd_ctrl
    import txd_pkg::*;
#(
    parameter int RING_WORDS = 16,
    parameter int MAX_FRAME  = 64,
    parameter int AW         = 32,
    localparam int IW        = $clog2(RING_WORDS),
    localparam int PW        = $clog2(MAX_FRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_crc_all,
    input  logic              cfg_crc_late,
    input  logic              irq_mask_ok,
    input  logic              irq_mask_err,
    input  logic [1:0]        src_clr,
    output logic [IW-1:0]     dr_addr,
    input  logic [31:0]       dr_rdata,
    output logic              dr_we,
    output logic [31:0]       dr_wdata,
    output logic              fetch_go,
    output logic [AW-1:0]     frame_ptr,
    output logic [LEN_W-1:0]  frame_len,
    input  logic              fetch_done,
    output logic [PW-1:0]     rd_pos,
    input  logic [7:0]        rd_byte,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              tx_done,
    input  logic              tx_fail,
    output logic              crc_add,
    output logic              crc_late,
    output logic [1:0]        int_src,
    output logic              irq
);
    localparam logic [IW-1:0] LAST_PAIR = IW'(RING_WORDS - 2);

    txd_state_e       state;
    logic             ptr_phase;
    logic [IW-1:0]    idx;
    logic [IW-1:0]    next_idx;
    logic [31:0]      stat_q;
    logic [PW-1:0]    pos;
    logic             drained;
    logic             finish;
    logic [31:0]      wb_word;

    assign frame_len = stat_q[LEN_LSB +: LEN_W];
    assign fetch_go  = (state == ST_FETCH);
    assign dr_addr   = (state == ST_WAIT && ptr_phase) ? idx + IW'(1) : idx;
    assign tx_valid  = (state == ST_SEND) && !drained;
    assign rd_pos    = pos;
    assign tx_data   = rd_byte;
    assign tx_last   = (LEN_W'(pos) == frame_len - LEN_W'(1));
    assign finish    = (state == ST_SEND) && drained && (tx_done || tx_fail);
    assign dr_we     = finish;
    assign dr_wdata  = wb_word;
    assign next_idx  = (stat_q[B_WRAP] || idx >= LAST_PAIR) ? '0 : idx + IW'(2);

    // Status word returned to the descriptor; failure also drops collision.
    always_comb begin
        wb_word          = stat_q;
        wb_word[B_READY] = 1'b0;
        if (tx_fail) wb_word[B_COLL] = 1'b0;
    end

    // Main sequencer across poll, fetch and send phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ptr_phase <= 1'b0;
            idx       <= '0;
            stat_q    <= '0;
            frame_ptr <= '0;
            crc_add   <= 1'b0;
            crc_late  <= 1'b0;
            pos       <= '0;
            drained   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    ptr_phase <= 1'b0;
                    if (cfg_tx_en) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!ptr_phase) begin
                        if (!cfg_tx_en) begin
                            state <= ST_IDLE;
                        end else if (dr_rdata[B_READY]) begin
                            stat_q    <= dr_rdata;
                            ptr_phase <= 1'b1;
                        end
                    end else begin
                        frame_ptr <= AW'(dr_rdata);
                        crc_add   <= cfg_crc_all || (stat_q[B_CRC] && stat_q[B_LAST]);
                        crc_late  <= cfg_crc_late;
                        ptr_phase <= 1'b0;
                        state     <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        state   <= ST_SEND;
                        pos     <= '0;
                        drained <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (tx_valid && tx_ready) begin
                        if (tx_last) drained <= 1'b1;
                        else         pos     <= pos + PW'(1);
                    end
                    if (finish) begin
                        state <= ST_IDLE;
                        idx   <= next_idx;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky interrupt sources with write-one-to-clear, and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_src <= 2'b00;
            irq     <= 1'b0;
        end else begin
            int_src[0] <= (int_src[0] && !src_clr[0]) || (finish && !tx_fail);
            int_src[1] <= (int_src[1] && !src_clr[1]) || (finish && tx_fail);
            irq        <= finish && (irq_mask_ok || irq_mask_err);
        end
    end

    // R5: accepted descriptors carry a length the buffer can hold
    a_r5_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && ptr_phase) |-> (frame_len != '0 && frame_len <= LEN_W'(MAX_FRAME)));
    // R8: descriptor RAM is written only on a sink response
    a_r8_we_on_response: assert property (@(posedge clk) disable iff (!rst_n)
        dr_we |-> (tx_done || tx_fail));
    // R9: a failed send leaves the error source set
    a_r9_fail_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_we && tx_fail) |=> int_src[1]);
    // R11: the interrupt is a single-cycle pulse
    a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R12: a set source survives unless its own clear bit is written
    a_r12_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (int_src[0] && !src_clr[0]) |=> int_src[0]);
endmodule

// File: rtl/txdesc_dma_engine.sv
`timescale 1ns/1ps
// Transmit descriptor DMA engine top: joins the sequencer, the word fetcher
// and the frame buffer. Assumes RING_WORDS is an even power of two and
// MAX_FRAME a power of two that is a multiple of 4.
module txdesc_dma_engine #(
    parameter int RING_WORDS = 16,
    parameter int MAX_FRAME  = 64,
    parameter int AW         = 32,
    localparam int IW        = $clog2(RING_WORDS),
    localparam int PW        = $clog2(MAX_FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_tx_en,
    input  logic          cfg_crc_all,
    input  logic          cfg_crc_late,
    input  logic          irq_mask_ok,
    input  logic          irq_mask_err,
    input  logic [1:0]    src_clr,
    output logic [IW-1:0] dr_addr,
    input  logic [31:0]   dr_rdata,
    output logic          dr_we,
    output logic [31:0]   dr_wdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          tx_done,
    input  logic          tx_fail,
    output logic          crc_add,
    output logic          crc_late,
    output logic [1:0]    int_src,
    output logic          irq
);
    logic                         fetch_go;
    logic                         fetch_done;
    logic [AW-1:0]                frame_ptr;
    logic [txd_pkg::LEN_W-1:0]    frame_len;
    logic                         buf_we;
    logic [PW-1:0]                buf_wpos;
    logic [31:0]                  buf_word;
    logic [PW-1:0]                buf_rpos;
    logic [7:0]                   buf_byte;

    txd_ctrl #(.RING_WORDS(RING_WORDS), .MAX_FRAME(MAX_FRAME), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_tx_en(cfg_tx_en), .cfg_crc_all(cfg_crc_all), .cfg_crc_late(cfg_crc_late),
        .irq_mask_ok(irq_mask_ok), .irq_mask_err(irq_mask_err), .src_clr(src_clr),
        .dr_addr(dr_addr), .dr_rdata(dr_rdata), .dr_we(dr_we), .dr_wdata(dr_wdata),
        .fetch_go(fetch_go), .frame_ptr(frame_ptr), .frame_len(frame_len),
        .fetch_done(fetch_done), .rd_pos(buf_rpos), .rd_byte(buf_byte),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .tx_done(tx_done), .tx_fail(tx_fail), .crc_add(crc_add), .crc_late(crc_late),
        .int_src(int_src), .irq(irq)
    );

    txd_fetch #(.AW(AW), .DEPTH(MAX_FRAME)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(fetch_go), .base(frame_ptr), .len(frame_len),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wr_en(buf_we), .wr_pos(buf_wpos), .wr_word(buf_word), .done(fetch_done)
    );

    txd_fbuf #(.DEPTH(MAX_FRAME)) u_fbuf (
        .clk(clk), .wr_en(buf_we), .wr_pos(buf_wpos), .wr_word(buf_word),
        .rd_pos(buf_rpos), .rd_byte(buf_byte)
    );

    // R6: the fetch side and the stream side are never active together
    a_r6_no_send_while_fetching: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !tx_valid);
endmodule

// File: tb/sim_txdesc_dma_engine.sv
`timescale 1ns/1ps
module sim_txdesc_dma_engine;
    localparam int RW = 16;

    typedef struct packed {
        logic [15:0] len;
        logic [31:0] ptr;
        logic wrap, crc, last, coll, fail, both, mok, merr, crc_all, crc_dly, stall, bp;
        logic [3:0]  exp_next;
        logic exp_crc, exp_irq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd8,  32'h0000_0100, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0, 4'd2, 1'b0,1'b1},
        '{16'd5,  32'h0000_0204, 1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0, 1'b0,1'b1, 1'b0,1'b1, 1'b0,1'b0, 4'd4, 1'b1,1'b1},
        '{16'd1,  32'h0000_0300, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0, 4'd6, 1'b0,1'b0},
        '{16'd13, 32'h0000_040C, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 1'b1,1'b1, 1'b1,1'b1, 1'b0,1'b1, 4'd0, 1'b1,1'b1},
        '{16'd64, 32'h0000_1000, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 4'd2, 1'b0,1'b0},
        '{16'd3,  32'h0000_02F0, 1'b0,1'b1,1'b1,1'b0, 1'b1,1'b1, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0, 4'd4, 1'b1,1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_tx_en = 1'b0, cfg_crc_all = 1'b0, cfg_crc_late = 1'b0;
    logic irq_mask_ok = 1'b0, irq_mask_err = 1'b0;
    logic [1:0] src_clr = 2'b00;
    logic [3:0] dr_addr;
    logic [31:0] dr_rdata, dr_wdata, mem_addr, mem_rdata;
    logic dr_we, mem_req, mem_ack, tx_valid, tx_last, tx_ready, crc_add, crc_late, irq;
    logic [7:0] tx_data;
    logic tx_done = 1'b0, tx_fail = 1'b0;
    logic [1:0] int_src;

    logic [31:0] dram [RW];
    logic host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [31:0] host_data = '0;
    logic stall_mode = 1'b0, bp_mode = 1'b0, ack_ok = 1'b1, rdy = 1'b1;
    int n_chk = 0, n_bad = 0, exp_idx = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    initial for (int i = 0; i < RW; i++) dram[i] = '0;
    always @(posedge clk) begin
        if (dr_we)        dram[dr_addr]   <= dr_wdata;
        else if (host_we) dram[host_addr] <= host_data;
        ack_ok <= stall_mode ? ~ack_ok : 1'b1;
        rdy    <= bp_mode ? ~rdy : 1'b1;
    end
    assign dr_rdata  = dram[dr_addr];
    assign mem_ack   = mem_req & ack_ok;
    assign mem_rdata = {pat(mem_addr), pat(mem_addr + 1), pat(mem_addr + 2), pat(mem_addr + 3)};
    assign tx_ready  = rdy;

    txdesc_dma_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_crc_all(cfg_crc_all),
        .cfg_crc_late(cfg_crc_late), .irq_mask_ok(irq_mask_ok), .irq_mask_err(irq_mask_err),
        .src_clr(src_clr), .dr_addr(dr_addr), .dr_rdata(dr_rdata), .dr_we(dr_we),
        .dr_wdata(dr_wdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_done(tx_done), .tx_fail(tx_fail), .crc_add(crc_add),
        .crc_late(crc_late), .int_src(int_src), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [31:0] d);
        host_addr = 4'(a); host_data = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic run_frame(input vec_t v);
        logic [31:0] st, wb;
        int cur, nb, nr, guard, nwords;
        bit got, dly0;
        cfg_crc_all = v.crc_all; cfg_crc_late = v.crc_dly;
        irq_mask_ok = v.mok; irq_mask_err = v.merr;
        stall_mode = v.stall; bp_mode = v.bp; src_clr = 2'b11;
        @(negedge clk);
        src_clr = 2'b00;
        chk(int_src == 2'b00, "R12 sources cleared", 32'(int_src), 0);
        cur = int'(dr_addr);
        chk(cur == exp_idx, "R10 polling index", 32'(cur), 32'(exp_idx));
        st = {v.len, 1'b1, v.wrap, v.crc, v.last, 8'h00, v.coll, 3'b000};
        nwords = (int'(v.len) + 3) / 4;
        host_wr(cur + 1, v.ptr);
        host_wr(cur, st);
        nb = 0; nr = 0; got = 0; guard = 0; dly0 = v.crc_dly;
        while (!got && guard < 4000) begin
            if (mem_req && mem_ack) begin
                if (nr == 0) chk(mem_addr == v.ptr, "R3 pointer from index+1", mem_addr, v.ptr);
                chk(mem_addr == v.ptr + 32'(4 * nr), "R4 read address", mem_addr, v.ptr + 32'(4 * nr));
                nr++;
            end
            if (tx_valid && tx_ready) begin
                if (nb == 0) chk(nr == nwords, "R6 all words read before send", 32'(nr), 32'(nwords));
                chk(tx_data == pat(v.ptr + 32'(nb)), "R5 stream byte", 32'(tx_data), 32'(pat(v.ptr + 32'(nb))));
                if (tx_last) begin
                    chk(nb == int'(v.len) - 1, "R5 last flag position", 32'(nb), 32'(v.len) - 1);
                    chk(crc_add == v.exp_crc, "R7 crc append", 32'(crc_add), 32'(v.exp_crc));
                    chk(crc_late == dly0, "R7 late crc held", 32'(crc_late), 32'(dly0));
                    got = 1;
                end
                nb++;
                if (nb == 1) cfg_crc_late = ~dly0;
            end
            if (!got) begin @(negedge clk); guard++; end
        end
        chk(got, "R5 frame end seen", 32'(nb), 32'(v.len));
        @(negedge clk);
        chk(tx_valid == 1'b0, "R5 no byte after last", 32'(tx_valid), 0);
        tx_done = !v.fail || v.both; tx_fail = v.fail;
        @(negedge clk);
        tx_done = 1'b0; tx_fail = 1'b0;
        wb = st & ~32'h0000_8000;
        if (v.fail) wb = wb & ~32'h0000_0008;
        if (v.fail) begin
            chk(dram[cur] == wb, "R9 failed status writeback", dram[cur], wb);
            chk(int_src == 2'b10, "R9 error source", 32'(int_src), 2);
        end else begin
            chk(dram[cur] == wb, "R8 good status writeback", dram[cur], wb);
            chk(int_src == 2'b01, "R8 sent source", 32'(int_src), 1);
        end
        chk(irq == v.exp_irq, "R11 irq after response", 32'(irq), 32'(v.exp_irq));
        chk(dr_addr == v.exp_next, "R10 next index", 32'(dr_addr), 32'(v.exp_next));
        chk(nr == nwords, "R4 word read count", 32'(nr), 32'(nwords));
        @(negedge clk);
        chk(irq == 1'b0, "R11 irq single cycle", 32'(irq), 0);
        exp_idx = int'(v.exp_next);
    endtask

    initial begin
        bit seen;
        vec_t w;
        repeat (3) @(negedge clk);
        chk(dr_addr == 0 && !mem_req && !tx_valid && !dr_we && !irq && int_src == 0,
            "R1 state in reset", {dr_addr, mem_req, tx_valid, dr_we, irq, int_src}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dr_addr == 0 && !mem_req && !tx_valid && !irq && int_src == 0,
            "R1 state after reset", {dr_addr, mem_req, tx_valid, irq, int_src}, 0);

        // R2: a ready descriptor is left alone while disabled
        host_wr(1, 32'h80);
        host_wr(0, {16'd4, 1'b1, 15'd0});
        seen = 0;
        repeat (20) begin @(negedge clk); seen |= (mem_req | tx_valid); end
        chk(!seen, "R2 disabled engine reads nothing", 32'(seen), 0);
        host_wr(0, 32'h0);
        cfg_tx_en = 1'b1;
        repeat (6) @(negedge clk);
        cfg_tx_en = 1'b0;
        repeat (3) @(negedge clk);
        host_wr(0, {16'd4, 1'b1, 15'd0});
        seen = 0;
        repeat (15) begin @(negedge clk); seen |= (mem_req | tx_valid); end
        chk(!seen, "R2 disable while polling returns idle", 32'(seen), 0);
        // R3: a not-ready descriptor is only polled
        host_wr(0, {16'd4, 1'b0, 15'd0});
        cfg_tx_en = 1'b1;
        seen = 0;
        repeat (15) begin @(negedge clk); seen |= (mem_req | tx_valid); end
        chk(!seen, "R3 not-ready descriptor skipped", 32'(seen), 0);
        host_wr(0, 32'h0);

        for (int i = 0; i < 6; i++) run_frame(VECS[i]);

        // R10: index reaches the last pair and returns to 0 without wrap bit
        for (int k = 0; k < 6; k++) begin
            w = '0;
            w.len = 16'(4 + k);
            w.ptr = 32'h3000 + 32'(k * 256);
            w.mok = 1'b1;
            w.exp_irq = 1'b1;
            w.exp_next = (exp_idx >= RW - 2) ? 4'd0 : 4'(exp_idx + 2);
            run_frame(w);
        end
        chk(exp_idx == 0, "R10 ring end returns to zero", 32'(exp_idx), 0);

        // R12: sticky source and selective clearing
        repeat (4) @(negedge clk);
        chk(int_src == 2'b01, "R12 source stays set", 32'(int_src), 1);
        src_clr = 2'b10;
        @(negedge clk);
        src_clr = 2'b00;
        @(negedge clk);
        chk(int_src == 2'b01, "R12 other clear bit no effect", 32'(int_src), 1);
        src_clr = 2'b01;
        @(negedge clk);
        src_clr = 2'b00;
        @(negedge clk);
        chk(int_src == 2'b00, "R12 write one clears", 32'(int_src), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired (run hung)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule